// File: doc/BRIEF.md
# Split-Accumulation Transposed FIR Filter

This block is a fixed-coefficient FIR filter in transposed form. Each accepted input sample is multiplied by every coefficient in the same cycle. The products are added into a chain of registered partial sums, so the delay falls on the sums and not on the sample. All coefficients, the tap count, the input and coefficient widths, the split bit position and the number of optimized output-side taps are elaboration-time parameters. The result is a full-precision signed value, with no rounding or truncation.

Close to the output the coefficient products are much narrower than the running sum. A plain full-width adder there spends most of its width on sign extension. For the last `OPT_TAPS` taps, the wide partial sum is therefore cut at bit `SPLIT_POS`. The part above the cut is delayed through those taps without being added to. The part below the cut is zero-extended into a short signed accumulator, and the narrow products are summed there. A single merge adder at the output adds the accumulator's bits at and above the cut, sign-extended, to the delayed upper part. The bits below the cut go straight to the output. With `OPT_TAPS = 0` the block is an ordinary transposed filter.

Top module: `split_acc_fir`

## Requirements
- R1: When `in_valid` is high at a rising edge, that sample x[n] is accepted. At that same edge `out_sample` becomes the sum over k of h_k·x[n−k], taken over the samples accepted since reset, with earlier samples counted as zero. Coefficient h_k is the signed `COEF_W`-bit field at bits [k·COEF_W +: COEF_W] of `COEFS`, and h_0 weights the newest sample.
- R2: The result is exact two's complement in `ACC_W` = IN_W + COEF_W + ceil(log2 N_TAPS) bits. This holds for long runs of full-scale positive (+127) and full-scale negative (−128) samples.
- R3: With `OPT_TAPS = 0` there is no split and no merge adder. The output matches the split configuration bit for bit on the same input stream.
- R4: The deepest split, `OPT_TAPS = N_TAPS−1`, where only the farthest tap stays wide, gives the exact R1 result.
- R5: `out_valid` is `in_valid` delayed by exactly one clock. The split adds no latency, and every accepted sample yields exactly one valid result.
- R6: While `in_valid` is low, `in_sample` is ignored. `out_sample` holds its value, and no tap register moves, so the next result still follows R1 as if the idle cycles were absent.
- R7: A synchronous active-high `rst` sets `out_valid` and `out_sample` to zero and clears all history. A sample presented together with `rst` is not accepted.
- R8: Carries and borrows between the low accumulator and the delayed upper part are kept. Sign-alternating full-scale inputs, whose partial sums cross bit `SPLIT_POS` in both directions, still give the exact R1 result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Strobe that accepts `in_sample` at this edge |
| in_sample | input | IN_W | Signed input sample |
| out_valid | output | 1 | High for one cycle after each accepted sample |
| out_sample | output | ACC_W | Signed full-precision filter result |

## Verification
A wrong bit in a delayed upper register, or a lost overlap bit in the low accumulator, appears at the output as an error of a multiple of 2^SPLIT_POS. A wrong low bit appears as a small offset. Either one reaches `out_sample` within at most `OPT_TAPS` accepted samples and then leaves the window. Three variants (split, unsplit and deepest split) are compared result by result against a model computed in the bench from the coefficients, so a fault is caught on the first result it reaches. Idle cycles check that the output holds. Reset cycles check that the history is gone, because an impulse right after reset must reproduce the coefficients.

// File: rtl/fsa_pkg.sv
`timescale 1ns/1ps
package fsa_pkg;

   // full-precision accumulator width for a sum of TAPS products
   function automatic int acc_width(input int in_w, input int coef_w, input int taps);
      return in_w + coef_w + $clog2(taps);
   endfunction

   // low accumulator: S split bits, growth for K products plus the low part, sign bit
   function automatic int low_width(input int split_pos, input int opt_taps);
      return split_pos + $clog2(opt_taps + 1) + 1;
   endfunction

endpackage

// File: rtl/fsa_prod_bank.sv
`timescale 1ns/1ps
module fsa_prod_bank #(
   parameter int                        IN_W   = 8,
   parameter int                        COEF_W = 8,
   parameter int                        N_TAPS = 8,
   parameter logic [N_TAPS*COEF_W-1:0]  COEFS  = '0,
   parameter int                        FIRST  = 0,
   parameter int                        COUNT  = 1,
   parameter int                        P_W    = 16
) (
   input  logic signed [IN_W-1:0]     sample,
   output logic [COUNT-1:0][P_W-1:0]  prod
);
   localparam int FW = IN_W + COEF_W;

   for (genvar j = 0; j < COUNT; j++) begin : g_mul
      localparam logic signed [COEF_W-1:0] C = COEFS[(FIRST+j)*COEF_W +: COEF_W];
      // product computed at its natural width, then resized to the lane width
      assign prod[j] = P_W'(FW'(sample) * FW'(C));
   end

endmodule

// File: rtl/fsa_wide_chain.sv
`timescale 1ns/1ps
module fsa_wide_chain #(
   parameter int AW    = 19,
   parameter int N_REG = 4
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       adv,
   input  logic [N_REG:0][AW-1:0]     prod,
   output logic signed [AW-1:0]       head_sum
);
   // q[j] is the delayed partial sum entering tap j; q[N_REG] is the empty end
   logic signed [AW-1:0] q   [N_REG+1];
   logic signed [AW-1:0] sum [N_REG+1];

   assign q[N_REG] = '0;

   for (genvar j = 0; j <= N_REG; j++) begin : g_add
      assign sum[j] = $signed(prod[j]) + q[j];
   end

   for (genvar j = 0; j < N_REG; j++) begin : g_reg
      always_ff @(posedge clk) begin
         if (rst)      q[j] <= '0;
         else if (adv) q[j] <= sum[j+1];
      end
   end

   assign head_sum = sum[0];

endmodule

// File: rtl/fsa_split_tail.sv
`timescale 1ns/1ps
module fsa_split_tail #(
   parameter int AW = 19,
   parameter int S  = 10,
   parameter int K  = 3,
   parameter int LW = 13
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     adv,
   input  logic signed [AW-1:0]     wide_sum,
   input  logic [K-1:0][LW-1:0]     prod,
   output logic signed [AW-1:0]     y
);
   localparam int HW = AW - S;

   logic signed [HW-1:0] hi_q [K];
   logic signed [LW-1:0] lo_q [K];
   logic signed [LW-1:0] lo_fin;
   logic signed [AW-1:0] y_next;

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int j = 0; j < K; j++) begin
            hi_q[j] <= '0;
            lo_q[j] <= '0;
         end
      end else if (adv) begin
         // split: upper part delayed untouched, lower part zero-extended
         hi_q[K-1] <= HW'(wide_sum >>> S);
         lo_q[K-1] <= LW'(wide_sum[S-1:0]);
         for (int j = 0; j < K-1; j++) begin
            hi_q[j] <= hi_q[j+1];
            lo_q[j] <= lo_q[j+1] + $signed(prod[j+1]);
         end
      end
   end

   // merge: overlap bits are a signed correction to the upper part
   assign lo_fin = lo_q[0] + $signed(prod[0]);
   assign y_next = {hi_q[0] + HW'($signed(lo_fin[LW-1:S])), lo_fin[S-1:0]};

   always_ff @(posedge clk) begin
      if (rst)      y <= '0;
      else if (adv) y <= y_next;
   end

endmodule

// File: rtl/split_acc_fir.sv
`timescale 1ns/1ps
module split_acc_fir #(
   parameter int                        IN_W      = 8,
   parameter int                        COEF_W    = 8,
   parameter int                        N_TAPS    = 8,
   parameter logic [N_TAPS*COEF_W-1:0]  COEFS     = 64'hFE13_D870_3905_FA03,
   parameter int                        SPLIT_POS = 10,
   parameter int                        OPT_TAPS  = 3,
   parameter int                        ACC_W     = fsa_pkg::acc_width(IN_W, COEF_W, N_TAPS)
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      in_valid,
   input  logic signed [IN_W-1:0]    in_sample,
   output logic                      out_valid,
   output logic signed [ACC_W-1:0]   out_sample
);
   localparam int LAST  = OPT_TAPS;
   localparam int N_REG = N_TAPS - 1 - LAST;
   localparam int LO_W  = fsa_pkg::low_width(SPLIT_POS, OPT_TAPS);

   // elaboration-time parameter checks
   if (N_TAPS < 2) begin : g_bad_taps
      $error("split_acc_fir: N_TAPS must be at least 2");
   end
   if (OPT_TAPS < 0 || OPT_TAPS > N_TAPS - 1) begin : g_bad_opt
      $error("split_acc_fir: OPT_TAPS must lie in 0..N_TAPS-1");
   end
   if (OPT_TAPS > 0 && (SPLIT_POS < 1 || SPLIT_POS >= ACC_W)) begin : g_bad_split
      $error("split_acc_fir: SPLIT_POS must lie in 1..ACC_W-1");
   end
   if (OPT_TAPS > 0 && (ACC_W - SPLIT_POS) < (LO_W - SPLIT_POS)) begin : g_bad_hi
      $error("split_acc_fir: upper part narrower than the low overlap");
   end
   for (genvar k = 0; k < OPT_TAPS; k++) begin : g_coef_chk
      localparam logic signed [COEF_W-1:0] CK = COEFS[k*COEF_W +: COEF_W];
      localparam longint MAG = (CK < 0) ? -longint'(CK) : longint'(CK);
      if (MAG * (longint'(1) << (IN_W-1)) >= (longint'(1) << SPLIT_POS)) begin : g_bad_coef
         $error("split_acc_fir: optimized tap product does not fit below SPLIT_POS");
      end
   end

   // wide products and full-width chain for taps LAST..N_TAPS-1
   logic [N_REG:0][ACC_W-1:0] prod_w;
   logic signed [ACC_W-1:0]   head_sum;
   logic signed [ACC_W-1:0]   y_int;

   fsa_prod_bank #(
      .IN_W(IN_W), .COEF_W(COEF_W), .N_TAPS(N_TAPS), .COEFS(COEFS),
      .FIRST(LAST), .COUNT(N_REG+1), .P_W(ACC_W)
   ) u_bank_wide (
      .sample(in_sample),
      .prod  (prod_w)
   );

   fsa_wide_chain #(.AW(ACC_W), .N_REG(N_REG)) u_chain (
      .clk     (clk),
      .rst     (rst),
      .adv     (in_valid),
      .prod    (prod_w),
      .head_sum(head_sum)
   );

   if (OPT_TAPS == 0) begin : g_plain
      logic signed [ACC_W-1:0] y_q;
      always_ff @(posedge clk) begin
         if (rst)           y_q <= '0;
         else if (in_valid) y_q <= head_sum;
      end
      assign y_int = y_q;
   end else begin : g_split
      logic [OPT_TAPS-1:0][LO_W-1:0] prod_n;

      fsa_prod_bank #(
         .IN_W(IN_W), .COEF_W(COEF_W), .N_TAPS(N_TAPS), .COEFS(COEFS),
         .FIRST(0), .COUNT(OPT_TAPS), .P_W(LO_W)
      ) u_bank_narrow (
         .sample(in_sample),
         .prod  (prod_n)
      );

      fsa_split_tail #(.AW(ACC_W), .S(SPLIT_POS), .K(OPT_TAPS), .LW(LO_W)) u_tail (
         .clk     (clk),
         .rst     (rst),
         .adv     (in_valid),
         .wide_sum(head_sum),
         .prod    (prod_n),
         .y       (y_int)
      );
   end

   logic valid_q;
   always_ff @(posedge clk) begin
      if (rst) valid_q <= 1'b0;
      else     valid_q <= in_valid;
   end

   assign out_valid  = valid_q;
   assign out_sample = y_int;

endmodule

// File: rtl/fsa_fir_chk.sv
`timescale 1ns/1ps
module fsa_fir_chk #(
   parameter int                        IN_W   = 8,
   parameter int                        COEF_W = 8,
   parameter int                        N_TAPS = 8,
   parameter logic [N_TAPS*COEF_W-1:0]  COEFS  = '0,
   parameter int                        ACC_W  = 19
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     in_valid,
   input  logic signed [IN_W-1:0]   in_sample,
   input  logic                     out_valid,
   input  logic signed [ACC_W-1:0]  out_sample
);
   // direct-form model of the accepted history
   logic signed [IN_W-1:0]  hist [N_TAPS-1];
   logic signed [ACC_W-1:0] ref_y;

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int j = 0; j < N_TAPS-1; j++) hist[j] <= '0;
      end else if (in_valid) begin
         hist[0] <= in_sample;
         for (int j = 1; j < N_TAPS-1; j++) hist[j] <= hist[j-1];
      end
   end

   always_comb begin
      longint acc;
      acc = longint'($signed(COEFS[COEF_W-1:0])) * longint'(in_sample);
      for (int k = 1; k < N_TAPS; k++)
         acc += longint'($signed(COEFS[k*COEF_W +: COEF_W])) * longint'(hist[k-1]);
      ref_y = ACC_W'(acc);
   end

   assert_match_reference_R1: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> (out_sample == $past(ref_y)));

   assert_valid_follows_R5: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);

   assert_no_spurious_valid_R5: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid);

   assert_hold_when_idle_R6: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> $stable(out_sample));

   assert_reset_clears_R7: assert property (@(posedge clk)
      rst |=> (!out_valid && out_sample == '0));

endmodule

bind split_acc_fir fsa_fir_chk #(
   .IN_W(IN_W), .COEF_W(COEF_W), .N_TAPS(N_TAPS), .COEFS(COEFS), .ACC_W(ACC_W)
) u_fsa_chk (
   .clk       (clk),
   .rst       (rst),
   .in_valid  (in_valid),
   .in_sample (in_sample),
   .out_valid (out_valid),
   .out_sample(out_sample)
);

// File: tb/test_split_acc_fir.sv
`timescale 1ns/1ps
module test_split_acc_fir;
   localparam int IN_W = 8, COEF_W = 8, N_TAPS = 8, SPLIT = 10, ACC_W = 19;
   localparam logic [63:0] COEFS_A = 64'hFE13_D870_3905_FA03;
   localparam logic [63:0] COEFS_B = 64'h04FA_0107_FD05_F902;
   int ca [N_TAPS] = '{3, -6, 5, 57, 112, -40, 19, -2};
   int cb [N_TAPS] = '{2, -7, 5, -3, 7, 1, -6, 4};

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic in_valid = 1'b0;
   logic [IN_W-1:0] in_sample = '0;
   logic vm, vp, vd;
   logic [ACC_W-1:0] om, op, od;

   always #10 clk = ~clk;

   split_acc_fir #(.IN_W(IN_W), .COEF_W(COEF_W), .N_TAPS(N_TAPS), .COEFS(COEFS_A),
      .SPLIT_POS(SPLIT), .OPT_TAPS(3)) i_split_acc_fir (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
      .out_valid(vm), .out_sample(om));

   split_acc_fir #(.IN_W(IN_W), .COEF_W(COEF_W), .N_TAPS(N_TAPS), .COEFS(COEFS_A),
      .SPLIT_POS(SPLIT), .OPT_TAPS(0)) i_split_acc_fir_plain (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
      .out_valid(vp), .out_sample(op));

   split_acc_fir #(.IN_W(IN_W), .COEF_W(COEF_W), .N_TAPS(N_TAPS), .COEFS(COEFS_B),
      .SPLIT_POS(SPLIT), .OPT_TAPS(N_TAPS-1)) i_split_acc_fir_deep (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
      .out_valid(vd), .out_sample(od));

   typedef struct { longint a; longint b; string req; } exp_t;
   exp_t exp_q [$];
   int   hist [N_TAPS];
   int   n_chk = 0, n_err = 0;
   bit   done = 0;
   string tag = "R1";
   longint lm = 0, lp = 0, ld = 0;

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic clear_model();
      for (int k = 0; k < N_TAPS; k++) hist[k] = 0;
   endtask

   // driver: presents one sample and pushes the expected results
   task automatic send(input int x);
      exp_t e;
      for (int k = N_TAPS-1; k > 0; k--) hist[k] = hist[k-1];
      hist[0] = x;
      e.a = 0; e.b = 0; e.req = tag;
      for (int k = 0; k < N_TAPS; k++) begin
         e.a += longint'(ca[k] * hist[k]);
         e.b += longint'(cb[k] * hist[k]);
      end
      exp_q.push_back(e);
      in_valid  = 1'b1;
      in_sample = IN_W'(x);
      @(negedge clk);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         in_valid  = 1'b0;
         in_sample = IN_W'($urandom);
         @(negedge clk);
      end
   endtask

   // monitor: compares results halfway between edges
   always @(posedge clk) begin
      #5;
      if (!done) begin
         if (rst) begin
            lm = 0; lp = 0; ld = 0;
         end else if (vm || vp || vd) begin
            check(vm && vp && vd, "R5 all variants valid together", {vm, vp, vd}, 3'b111);
            if (exp_q.size() == 0) begin
               check(1'b0, "R5 valid without accepted sample", 1, 0);
            end else begin
               exp_t e;
               e = exp_q.pop_front();
               check(longint'($signed(om)) == e.a, e.req, longint'($signed(om)), e.a);
               check(longint'($signed(op)) == e.a, "R3 unsplit variant", longint'($signed(op)), e.a);
               check(longint'($signed(od)) == e.b, "R4 deepest split", longint'($signed(od)), e.b);
            end
            lm = longint'($signed(om)); lp = longint'($signed(op)); ld = longint'($signed(od));
         end else begin
            // R6: idle cycle, every output holds
            check(longint'($signed(om)) == lm, "R6 hold split", longint'($signed(om)), lm);
            check(longint'($signed(op)) == lp, "R6 hold unsplit", longint'($signed(op)), lp);
            check(longint'($signed(od)) == ld, "R6 hold deep", longint'($signed(od)), ld);
         end
      end
   end

   task automatic check_reset_state();
      @(posedge clk); #5;
      check(!vm && !vp && !vd, "R7 valid low after reset", {vm, vp, vd}, 0);
      check(om == '0 && op == '0 && od == '0, "R7 outputs zero after reset",
            longint'($signed(om)) + longint'($signed(op)) + longint'($signed(od)), 0);
      @(negedge clk);
   endtask

   initial begin
      clear_model();
      repeat (3) @(negedge clk);
      rst = 1'b0;
      check_reset_state();

      tag = "R1 impulse";
      send(1);
      for (int i = 0; i < N_TAPS; i++) send(0);
      send(-1);
      idle(4);

      tag = "R2 full-scale positive";
      for (int i = 0; i < 12; i++) send(127);
      tag = "R2 full-scale negative";
      for (int i = 0; i < 12; i++) send(-128);
      idle(2);

      tag = "R8 alternating full scale";
      for (int i = 0; i < 20; i++) send((i % 2) ? -128 : 127);
      tag = "R8 small sign flips";
      for (int i = 0; i < 20; i++) send((i % 3 == 0) ? -1 : 1);
      for (int i = 0; i < 10; i++) send((i % 2) ? 127 : -1);

      tag = "R1 random with gaps";
      for (int i = 0; i < 400; i++) begin
         send(int'($signed(IN_W'($urandom))));
         if ($urandom_range(3) == 0) idle(1 + $urandom_range(2));
      end
      idle(1);

      // mid-run reset with a sample presented during reset
      rst = 1'b1;
      in_valid = 1'b1;
      in_sample = 8'h55;
      @(negedge clk);
      @(negedge clk);
      rst = 1'b0;
      in_valid = 1'b0;
      exp_q.delete();
      clear_model();
      check_reset_state();
      tag = "R7 history cleared";
      send(1);
      for (int i = 0; i < N_TAPS; i++) send(0);

      tag = "R1 random back to back";
      for (int i = 0; i < 200; i++) send(int'($signed(IN_W'($urandom))));
      idle(3);

      check(exp_q.size() == 0, "R5 every sample produced a result", exp_q.size(), 0);
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

endmodule